// File: doc/BRIEF.md
# Two-Wire Byte Memory Slave

This block is the bus-side front end of an 8K x 8 serial memory. It oversamples the two bus lines in the system clock domain, recognises bus START and STOP conditions, and answers only when the first byte after a START carries the device code 1010 followed by three select bits equal to its strap inputs. A write-mode transfer then carries a 13-bit word address in two bytes, most significant first, followed by any number of data bytes. Each data byte is passed, with its address, to a separate page buffer. A STOP after at least one data byte tells that buffer to start its write cycle. While the buffer reports busy, the slave acknowledges no control byte at all. This lets a bus master poll for completion.

Reads come from a synchronous RAM with one cycle of latency, addressed by a persistent pointer. Every byte accessed moves the pointer one past itself. A current-address read therefore continues where the previous access stopped. A random read loads the pointer with an address-only write before a repeated START. A sequential read keeps sending bytes as long as the master acknowledges, wrapping from the top address to zero.

The state machine has these states. IDLE waits for a START. CTRL shifts in the control byte, and CTRL_ACK drives its acknowledge. ADDR_HI and ADDR_HI_ACK handle the first address byte, and ADDR_LO and ADDR_LO_ACK handle the second. WDATA and WDATA_ACK handle each data byte. RDATA shifts a byte out and MACK samples the master's answer. IGNORE keeps the bus released. The transitions are as follows. A START from any state goes to CTRL, and a STOP from any state goes to IDLE. The falling SCL edge after the eighth bit moves CTRL to CTRL_ACK on a match, or to IGNORE on a mismatch or while busy. ADDR_HI, ADDR_LO and WDATA each move to their ACK state. At the end of an acknowledge clock, CTRL_ACK goes to RDATA for a read or to ADDR_HI for a write. ADDR_HI_ACK goes to ADDR_LO, ADDR_LO_ACK goes to WDATA, and WDATA_ACK goes back to WDATA. RDATA goes to MACK after eight bits. MACK goes back to RDATA on a master acknowledge, or to IGNORE on a master non-acknowledge.

Top module: `i2c_mem_slave`

## Requirements
- R1: The first byte after START is a control byte. Bits 7:4 must equal 1010 and bits 3:1 must equal `strap`, sent most significant bit first. Bit 0 selects the operation: 1 for read, 0 for write. On a match the slave drives SDA low through the ninth clock.
- R2: On a control-byte mismatch the slave sends no acknowledge and stays released for the following bytes. It issues no write handoff until the next START.
- R3: In a write transfer, two address bytes follow the control byte, high byte first. Each is acknowledged. The word address is the low 5 bits of the high byte followed by the 8 bits of the low byte; the top three bits of the high byte are ignored.
- R4: Each write data byte is acknowledged and produces exactly one single-cycle `wb_valid` pulse. The pulse carries the current pointer on `wb_addr` and the byte on `wb_data`. The pointer then advances by one.
- R5: A STOP that ends a transfer containing at least one data byte produces a single-cycle `wb_commit` pulse. A transfer without data bytes produces none.
- R6: A read-mode control byte returns the byte stored at the pointer, most significant bit first. The pointer always equals the last accessed address plus one.
- R7: A random read is an address-only write followed by a repeated START and a read-mode control byte. It returns the byte at the loaded address and issues no write handoff.
- R8: During a read, each master acknowledge makes the slave send the byte at the next address. The pointer wraps from 0x1FFF to 0x0000. After a master non-acknowledge the slave leaves SDA released.
- R9: While `wr_busy` is high, no control byte is acknowledged. Once it is low, the same control byte is acknowledged again.
- R10: A START received in the middle of a byte abandons that byte and restarts control-byte reception.
- R11: The open-drain enable changes only while synchronized SCL is low, and only HOLD_CYC system clocks after the SCL fall. The one exception is the release forced by a START or STOP.
- R12: After reset, SDA is released and neither handoff pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| strap | input | 3 | Device-select strap pins |
| wr_busy | input | 1 | Page buffer is in its write cycle |
| wb_valid | output | 1 | Write data byte handoff strobe |
| wb_addr | output | 13 | Address of the handed-off byte |
| wb_data | output | 8 | Handed-off data byte |
| wb_commit | output | 1 | Start-write-cycle strobe at STOP |
| mem_rd_addr | output | 13 | Read address to the RAM |
| mem_rd_data | input | 8 | RAM read data, one cycle after address |

## Verification
Two actions fall on the same SCL fall at the wrap point of a sequential read. The pointer increments from 0x1FFF while the RAM output for that address is latched into the shift register. The bench provokes this with a random read at 0x1FFE and acknowledges three bytes. It judges the result from the four byte values, which it computes from an arithmetic memory pattern, and from a current-address read that must then return address 0x0002. A second case checks that a START arriving half way through a byte is not mistaken for data.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_CTRL,
        S_CTRL_ACK,
        S_ADDR_HI,
        S_ADDR_HI_ACK,
        S_ADDR_LO,
        S_ADDR_LO_ACK,
        S_WDATA,
        S_WDATA_ACK,
        S_RDATA,
        S_MACK,
        S_IGNORE
    } slv_state_t;

    localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n)
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= line_i;
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n)
                    if (!rst_n) chain[g] <= 1'b1;
                    else        chain[g] <= chain[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) prev <= 1'b1;
        else        prev <= chain[STAGES-1];

    assign level_o = chain[STAGES-1];
    assign rise_o  = chain[STAGES-1] & ~prev;
    assign fall_o  = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/i2c_addr_ptr.sv
module i2c_addr_ptr #(
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] load_val_i,
    input  logic          inc_i,
    output logic [AW-1:0] ptr_o
);
    logic [AW-1:0] ptr_q;

    always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)      ptr_q <= '0;
        else if (load_i) ptr_q <= load_val_i;
        else if (inc_i)  ptr_q <= ptr_q + 1'b1;

    assign ptr_o = ptr_q;

    p_ptr_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(inc_i) && !$past(load_i) && ($past(ptr_q) == {AW{1'b1}})) |-> (ptr_q == '0));

    p_ptr_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load_i) |-> (ptr_q == $past(load_val_i)));
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
    import i2c_mem_pkg::*;
#(
    parameter int AW       = 13,
    parameter int SYNC     = 2,
    parameter int HOLD_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    input  logic [2:0]    strap,
    input  logic          wr_busy,
    output logic          wb_valid,
    output logic [AW-1:0] wb_addr,
    output logic [7:0]    wb_data,
    output logic          wb_commit,
    output logic [AW-1:0] mem_rd_addr,
    input  logic [7:0]    mem_rd_data
);
    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam int HI_W = AW - 8;

    logic scl_s, scl_rise, scl_fall;
    logic sda_s, sda_rise, sda_fall;
    logic start_det, stop_det;

    i2c_line_sync #(.STAGES(SYNC)) i_scl_sync (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i),
        .level_o(scl_s), .rise_o(scl_rise), .fall_o(scl_fall));
    i2c_line_sync #(.STAGES(SYNC)) i_sda_sync (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i),
        .level_o(sda_s), .rise_o(sda_rise), .fall_o(sda_fall));

    assign start_det = scl_s & sda_fall;
    assign stop_det  = scl_s & sda_rise;

    slv_state_t       state, state_d;
    logic [3:0]       bit_cnt;
    logic [7:0]       shreg, tx;
    logic             rw_q, m_ack, wrote;
    logic [HI_W-1:0]  addr_hi;
    logic [HW-1:0]    hold_cnt;
    logic             oe_tgt, byte_end, ctrl_hit, counting;
    logic             ptr_load, ptr_inc, enter_rd;
    logic [AW-1:0]    ptr;

    i2c_addr_ptr #(.AW(AW)) i_ptr (
        .clk(clk), .rst_n(rst_n), .load_i(ptr_load),
        .load_val_i({addr_hi, shreg}), .inc_i(ptr_inc), .ptr_o(ptr));

    assign mem_rd_addr = ptr;
    assign byte_end    = scl_fall && (bit_cnt == 4'd8);
    assign ctrl_hit    = (shreg[7:4] == DEV_CODE) && (shreg[3:1] == strap) && !wr_busy;
    assign counting    = (state == S_CTRL) || (state == S_ADDR_HI) || (state == S_ADDR_LO)
                      || (state == S_WDATA) || (state == S_RDATA);
    assign enter_rd    = !start_det && !stop_det && scl_fall
                      && (((state == S_CTRL_ACK) && rw_q) || ((state == S_MACK) && m_ack));
    assign ptr_load    = !start_det && !stop_det && byte_end && (state == S_ADDR_LO);
    assign ptr_inc     = enter_rd || (!start_det && !stop_det && byte_end && (state == S_WDATA));

    // Next-state process
    always_comb begin
        state_d = state;
        if (start_det)     state_d = S_CTRL;
        else if (stop_det) state_d = S_IDLE;
        else if (scl_fall) begin
            unique case (state)
                S_CTRL:        if (bit_cnt == 4'd8) state_d = ctrl_hit ? S_CTRL_ACK : S_IGNORE;
                S_CTRL_ACK:    state_d = rw_q ? S_RDATA : S_ADDR_HI;
                S_ADDR_HI:     if (bit_cnt == 4'd8) state_d = S_ADDR_HI_ACK;
                S_ADDR_HI_ACK: state_d = S_ADDR_LO;
                S_ADDR_LO:     if (bit_cnt == 4'd8) state_d = S_ADDR_LO_ACK;
                S_ADDR_LO_ACK: state_d = S_WDATA;
                S_WDATA:       if (bit_cnt == 4'd8) state_d = S_WDATA_ACK;
                S_WDATA_ACK:   state_d = S_WDATA;
                S_RDATA:       if (bit_cnt == 4'd8) state_d = S_MACK;
                S_MACK:        state_d = m_ack ? S_RDATA : S_IGNORE;
                default:       state_d = state;
            endcase
        end
    end

    // Output target for the open-drain driver
    always_comb begin
        unique case (state)
            S_CTRL_ACK, S_ADDR_HI_ACK, S_ADDR_LO_ACK, S_WDATA_ACK: oe_tgt = 1'b1;
            S_RDATA: oe_tgt = ~tx[3'd7 - bit_cnt[2:0]];
            default: oe_tgt = 1'b0;
        endcase
    end

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            tx       <= '0;
            rw_q     <= 1'b0;
            m_ack    <= 1'b0;
            wrote    <= 1'b0;
            addr_hi  <= '0;
            hold_cnt <= '0;
            sda_oe   <= 1'b0;
            wb_valid <= 1'b0;
            wb_addr  <= '0;
            wb_data  <= '0;
            wb_commit <= 1'b0;
        end else begin
            state     <= state_d;
            wb_valid  <= 1'b0;
            wb_commit <= stop_det && wrote;
            if (stop_det) wrote <= 1'b0;

            if (start_det || stop_det) begin
                bit_cnt <= '0;
            end else if (scl_rise) begin
                shreg <= {shreg[6:0], sda_s};
                if (counting) bit_cnt <= bit_cnt + 1'b1;
                if (state == S_MACK) m_ack <= ~sda_s;
            end else if (byte_end) begin
                bit_cnt <= '0;
                unique case (state)
                    S_CTRL:    rw_q <= shreg[0];
                    S_ADDR_HI: addr_hi <= shreg[HI_W-1:0];
                    S_WDATA: begin
                        wb_valid <= 1'b1;
                        wb_addr  <= ptr;
                        wb_data  <= shreg;
                        wrote    <= 1'b1;
                    end
                    default: ;
                endcase
            end
            if (enter_rd) tx <= mem_rd_data;

            if (start_det || stop_det) begin
                sda_oe   <= 1'b0;
                hold_cnt <= '0;
            end else if (scl_fall) begin
                hold_cnt <= HW'(HOLD_CYC);
            end else if (scl_rise) begin
                hold_cnt <= '0;
            end else if (hold_cnt != '0) begin
                hold_cnt <= hold_cnt - 1'b1;
                if (hold_cnt == HW'(1) && !scl_s) sda_oe <= oe_tgt;
            end
        end
    end

    p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe) && !$past(start_det || stop_det)) |-> !$past(scl_s));

    p_busy_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_CTRL_ACK) && ($past(state) == S_CTRL)) |-> !$past(wr_busy));

    p_wb_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> !wb_valid);

    p_commit_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_commit |-> $past(stop_det));

    p_ignore_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IGNORE) |-> (!wb_valid && !(ptr_load || ptr_inc)));
endmodule

// File: tb/test_i2c_mem_slave.sv
module test_i2c_mem_slave;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        wr_busy = 1'b0;
    logic [2:0]  strap = 3'b101;
    logic        sda_oe, wb_valid, wb_commit;
    logic [12:0] wb_addr, mem_rd_addr;
    logic [7:0]  wb_data, mem_rd_data;
    logic        bus_sda;

    int n_chk = 0, n_fail = 0;
    int wb_cnt = 0, cm_cnt = 0, hi_chg = 0;
    logic [12:0] wb_a_log [0:15];
    logic [7:0]  wb_d_log [0:15];
    logic        oe_prev = 1'b0, scl_prev = 1'b1;

    always #10 clk = ~clk;
    assign bus_sda = sda_m & ~sda_oe;

    i2c_mem_slave i_i2c_mem_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(bus_sda), .sda_oe(sda_oe),
        .strap(strap), .wr_busy(wr_busy), .wb_valid(wb_valid), .wb_addr(wb_addr),
        .wb_data(wb_data), .wb_commit(wb_commit), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data));

    function automatic logic [7:0] memf(input logic [12:0] a);
        return (a[7:0] + 8'h5A) ^ {3'b000, a[12:8]};
    endfunction

    always_ff @(posedge clk) mem_rd_data <= memf(mem_rd_addr);

    always @(posedge clk) begin
        if (wb_valid && wb_cnt < 16) begin
            wb_a_log[wb_cnt] <= wb_addr;
            wb_d_log[wb_cnt] <= wb_data;
        end
        if (wb_valid) wb_cnt <= wb_cnt + 1;
        if (wb_commit) cm_cnt <= cm_cnt + 1;
        if (scl_m && scl_prev && sda_oe !== oe_prev) hi_chg <= hi_chg + 1;
        oe_prev  <= sda_oe;
        scl_prev <= scl_m;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        scl_m = 1'b0; cyc(5); sda_m = 1'b1; cyc(5);
        scl_m = 1'b1; cyc(10); sda_m = 1'b0; cyc(10);
    endtask

    task automatic bus_stop();
        scl_m = 1'b0; cyc(5); sda_m = 1'b0; cyc(5);
        scl_m = 1'b1; cyc(10); sda_m = 1'b1; cyc(10);
    endtask

    task automatic wbits(input logic [7:0] d, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            scl_m = 1'b0; cyc(5); sda_m = d[i]; cyc(5);
            scl_m = 1'b1; cyc(10);
        end
    endtask

    task automatic wbyte(input logic [7:0] d, output bit ack);
        wbits(d, 8);
        scl_m = 1'b0; cyc(5); sda_m = 1'b1; cyc(5);
        scl_m = 1'b1; cyc(5); ack = (bus_sda == 1'b0); cyc(5);
    endtask

    task automatic rbyte(input bit give_ack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            scl_m = 1'b0; cyc(5); sda_m = 1'b1; cyc(5);
            scl_m = 1'b1; cyc(5); d[i] = bus_sda; cyc(5);
        end
        scl_m = 1'b0; cyc(5); sda_m = ~give_ack; cyc(5);
        scl_m = 1'b1; cyc(10);
    endtask

    task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo, output bit ok);
        bit a0, a1, a2;
        bus_start(); wbyte(8'hAA, a0); wbyte(hi, a1); wbyte(lo, a2);
        ok = a0 & a1 & a2;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        bit ack, ok;
        logic [7:0] rd;
        int wb0, cm0;
        cyc(4);
        rst_n = 1'b1;
        cyc(4);
        // R12
        chk(sda_oe == 1'b0 && wb_valid == 1'b0 && wb_commit == 1'b0, "R12 reset idle", {sda_oe, wb_valid, wb_commit}, 0);

        // R1 / R2 sweep of select bits
        for (int s = 0; s < 8; s++) begin
            bus_start(); wbyte({4'hA, 3'(s), 1'b0}, ack);
            chk(ack == (s == 5), "R1 select match sweep", ack, (s == 5));
            if (s == 0) begin
                wbyte(8'h00, ack);
                chk(!ack, "R2 ignored after mismatch", ack, 0);
            end
            bus_stop();
        end
        bus_start(); wbyte(8'hBA, ack); bus_stop();
        chk(!ack, "R1 wrong device code", ack, 0);
        chk(wb_cnt == 0, "R2 no handoff after mismatch", wb_cnt, 0);

        // R3 / R4 / R5 byte write
        set_addr(8'hE1, 8'h23, ok);
        chk(ok, "R3 address bytes acked", ok, 1);
        wbyte(8'h5C, ack);
        chk(ack, "R4 data byte acked", ack, 1);
        bus_stop(); cyc(4);
        chk(wb_cnt == 1 && wb_a_log[0] == 13'h0123 && wb_d_log[0] == 8'h5C, "R3 handoff addr/data",
            {wb_a_log[0], wb_d_log[0]}, {13'h0123, 8'h5C});
        chk(cm_cnt == 1, "R5 commit at stop", cm_cnt, 1);

        // R6 current address read
        bus_start(); wbyte(8'hAB, ack); rbyte(1'b0, rd);
        scl_m = 1'b0; cyc(9);
        chk(sda_oe == 1'b0, "R8 released after nack", sda_oe, 0);
        bus_stop();
        chk(rd == memf(13'h0124), "R6 current read", rd, memf(13'h0124));

        // R4 page write
        set_addr(8'h00, 8'h40, ok);
        wbyte(8'h11, ack); wbyte(8'h22, ack); wbyte(8'h33, ack);
        bus_stop(); cyc(4);
        chk(wb_cnt == 4 && wb_a_log[1] == 13'h0040 && wb_a_log[3] == 13'h0042 && wb_d_log[2] == 8'h22,
            "R4 page handoff", {wb_a_log[1], wb_a_log[3]}, {13'h0040, 13'h0042});
        chk(cm_cnt == 2, "R5 commit after page", cm_cnt, 2);

        // R7 random read
        wb0 = wb_cnt; cm0 = cm_cnt;
        set_addr(8'h04, 8'h56, ok);
        bus_start(); wbyte(8'hAB, ack); rbyte(1'b0, rd); bus_stop(); cyc(4);
        chk(rd == memf(13'h0456), "R7 random read", rd, memf(13'h0456));
        chk(wb_cnt == wb0 && cm_cnt == cm0, "R7 no write for address-only", wb_cnt, wb0);
        bus_start(); wbyte(8'hAB, ack); rbyte(1'b0, rd); bus_stop();
        chk(rd == memf(13'h0457), "R6 pointer last plus one", rd, memf(13'h0457));

        // R8 sequential read across wrap
        set_addr(8'h1F, 8'hFE, ok);
        bus_start(); wbyte(8'hAB, ack);
        for (int k = 0; k < 4; k++) begin
            logic [12:0] ea;
            ea = 13'h1FFE + 13'(k);
            rbyte(k != 3, rd);
            chk(rd == memf(ea), "R8 sequential byte", rd, memf(ea));
        end
        bus_stop();
        bus_start(); wbyte(8'hAB, ack); rbyte(1'b0, rd); bus_stop();
        chk(rd == memf(13'h0002), "R8 pointer after wrap", rd, memf(13'h0002));

        // R9 busy silence
        cm0 = cm_cnt;
        wr_busy = 1'b1;
        bus_start(); wbyte(8'hAA, ack); bus_stop();
        chk(!ack, "R9 no ack while busy", ack, 0);
        wr_busy = 1'b0;
        bus_start(); wbyte(8'hAA, ack); bus_stop(); cyc(4);
        chk(ack, "R9 ack after busy", ack, 1);
        chk(cm_cnt == cm0, "R5 no commit without data", cm_cnt, cm0);

        // R10 start mid-byte
        bus_start(); wbits(8'hAA, 4);
        bus_start(); wbyte(8'hAB, ack); rbyte(1'b0, rd); bus_stop();
        chk(ack && rd == memf(13'h0003), "R10 restart mid byte", rd, memf(13'h0003));

        cyc(10);
        chk(hi_chg == 0, "R11 drive change only with scl low", hi_chg, 0);
        summary();
    end
endmodule